// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches a bank of general-purpose input pins and raises an interrupt when a chosen edge appears on any of them. Each pin has three control bits. A select bit picks the active edge, rising or falling. The same bit also chooses which pull device the pin asks for: pull-down or pull-up. An enable bit lets the pin take part in the interrupt, and a sticky flag bit records that an active edge was seen. Software reaches these bits through a small register port in which every read is combinational.

Each pin input passes through a two-flop synchronizer. The edge detector then compares the synchronized level with a copy delayed by one cycle. An active edge sets the pin's flag, and the flag stays set until software writes a one to that bit. The interrupt request is one registered, active-high line: the OR over all pins of flag AND enable. A pull-enable register, gated by a per-pin input-direction signal, produces separate pull-up and pull-down control outputs for the pad ring.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset the pull-enable register (offset 0x14), the select register (0x15), the enable register (0x16) and the flag register (0x17) all read zero, and `irq` is 0. Bit i of each register belongs to pin i.
- R2: A read from any offset other than 0x14 to 0x17 returns zero. A write to such an offset changes no register.
- R3: With select bit i at 1, a rising edge on pin i sets flag i, and a falling edge does not.
- R4: With select bit i at 0, a falling edge on pin i sets flag i, and a rising edge does not.
- R5: A flag stays set until software writes 1 to its bit at 0x17. Writing 0 to a flag bit leaves it unchanged, and a write never sets a flag.
- R6: If an active edge and a write-1 clear of the same flag land on the same clock edge, the flag stays 1.
- R7: `irq` equals, one clock later, the OR over all pins of flag AND enable. An enable bit of 0 masks that pin's flag.
- R8: `pulldown_en[i]` is 1 only when pull-enable i, `pin_dir_in[i]` and select i are all 1. `pullup_en[i]` is 1 only when pull-enable i and `pin_dir_in[i]` are 1 and select i is 0.
- R9: A pin change that meets the input setup before a clock edge shows in the flag register after the third rising clock edge, not after the second. It shows on `irq` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Raw pin levels, asynchronous |
| pin_dir_in | input | 8 | Per-pin direction, 1 means the pin is an input |
| pullup_en | output | 8 | Pull-up request per pin |
| pulldown_en | output | 8 | Pull-down request per pin |
| irq | output | 1 | Combined interrupt request, registered, active high |

## Verification
The bound checker checks several rules on every cycle. It confirms that `irq` follows the masked flags one cycle later and that no pin ever requests both pulls. It also checks that a pull request needs both pull-enable and input direction, and that a flag only falls after a write of one to that bit at the flag offset. The bench scenarios cover what the checker cannot see: which edge polarity sets a flag, the exact three-edge latency from pin to flag, the case where a set and a clear land on the same edge, and the zero reads of unmapped offsets.

// File: rtl/pei_pkg.sv
package pei_pkg;
  // Register selected by a bus offset
  typedef enum logic [2:0] {
    RSEL_NONE = 3'd0,
    RSEL_PULL = 3'd1,
    RSEL_POL  = 3'd2,
    RSEL_MASK = 3'd3,
    RSEL_FLAG = 3'd4
  } rsel_e;
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] lvl,
  output logic [N_PINS-1:0] lvl_d
);
  logic [N_PINS-1:0] meta_q;
  logic [N_PINS-1:0] lvl_q;
  logic [N_PINS-1:0] dly_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        lvl_q[i]  <= 1'b0;
        dly_q[i]  <= 1'b0;
      end else begin
        meta_q[i] <= pin_in[i];
        lvl_q[i]  <= meta_q[i];
        dly_q[i]  <= lvl_q[i];
      end
    end
  end

  assign lvl   = lvl_q;
  assign lvl_d = dly_q;
endmodule

// File: rtl/pei_regs.sv
module pei_regs
  import pei_pkg::*;
#(
  parameter int          N_PINS   = 8,
  parameter int          ADDR_W   = 8,
  parameter int unsigned OFS_PULL = 32'h14,
  parameter int unsigned OFS_POL  = 32'h15,
  parameter int unsigned OFS_MASK = 32'h16,
  parameter int unsigned OFS_FLAG = 32'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  input  logic [N_PINS-1:0] flag_q,
  output logic [N_PINS-1:0] pull_q,
  output logic [N_PINS-1:0] pol_q,
  output logic [N_PINS-1:0] mask_q,
  output logic [N_PINS-1:0] flag_clr,
  output logic [N_PINS-1:0] bus_rdata
);
  rsel_e             rsel;
  logic [N_PINS-1:0] pull_d, pol_d, mask_d;
  logic              pull_we, pol_we, mask_we;

  // Offset decode
  always_comb begin
    if (bus_addr == ADDR_W'(OFS_PULL))      rsel = RSEL_PULL;
    else if (bus_addr == ADDR_W'(OFS_POL))  rsel = RSEL_POL;
    else if (bus_addr == ADDR_W'(OFS_MASK)) rsel = RSEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_FLAG)) rsel = RSEL_FLAG;
    else                                    rsel = RSEL_NONE;
  end

  // Write enables and next state
  always_comb begin
    pull_we  = bus_wr && (rsel == RSEL_PULL);
    pol_we   = bus_wr && (rsel == RSEL_POL);
    mask_we  = bus_wr && (rsel == RSEL_MASK);
    pull_d   = pull_we ? bus_wdata : pull_q;
    pol_d    = pol_we  ? bus_wdata : pol_q;
    mask_d   = mask_we ? bus_wdata : mask_q;
    flag_clr = (bus_wr && (rsel == RSEL_FLAG)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= '0;
      pol_q  <= '0;
      mask_q <= '0;
    end else begin
      pull_q <= pull_d;
      pol_q  <= pol_d;
      mask_q <= mask_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (rsel)
      RSEL_PULL: bus_rdata = pull_q;
      RSEL_POL:  bus_rdata = pol_q;
      RSEL_MASK: bus_rdata = mask_q;
      RSEL_FLAG: bus_rdata = flag_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pei_flags.sv
module pei_flags #(
  parameter int N_PINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] lvl,
  input  logic [N_PINS-1:0] lvl_d,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] mask,
  input  logic [N_PINS-1:0] flag_clr,
  output logic [N_PINS-1:0] flag_q,
  output logic              irq
);
  logic [N_PINS-1:0] hit;
  logic [N_PINS-1:0] flag_d;
  logic              irq_d;
  logic              irq_q;

  for (genvar i = 0; i < N_PINS; i++) begin : g_edge
    // pol = 1: rising edge is active; pol = 0: falling edge
    always_comb begin
      if (pol[i]) hit[i] = lvl[i] & ~lvl_d[i];
      else        hit[i] = ~lvl[i] & lvl_d[i];
    end
  end

  always_comb begin
    // a set on the same edge as a clear wins
    flag_d = (flag_q & ~flag_clr) | hit;
    irq_d  = |(flag_q & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int          N_PINS   = 8,
  parameter int          ADDR_W   = 8,
  parameter int unsigned OFS_PULL = 32'h14,
  parameter int unsigned OFS_POL  = 32'h15,
  parameter int unsigned OFS_MASK = 32'h16,
  parameter int unsigned OFS_FLAG = 32'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] pin_dir_in,
  output logic [N_PINS-1:0] pullup_en,
  output logic [N_PINS-1:0] pulldown_en,
  output logic              irq
);
  logic              rst_meta_q, rst_sync_n;
  logic [N_PINS-1:0] lvl, lvl_d;
  logic [N_PINS-1:0] pull_q, pol_q, mask_q, flag_q, flag_clr;

  // Reset: asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pei_sync #(.N_PINS(N_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in),
    .lvl    (lvl),
    .lvl_d  (lvl_d)
  );

  pei_regs #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W),
    .OFS_PULL(OFS_PULL), .OFS_POL(OFS_POL),
    .OFS_MASK(OFS_MASK), .OFS_FLAG(OFS_FLAG)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flag_q    (flag_q),
    .pull_q    (pull_q),
    .pol_q     (pol_q),
    .mask_q    (mask_q),
    .flag_clr  (flag_clr),
    .bus_rdata (bus_rdata)
  );

  pei_flags #(.N_PINS(N_PINS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lvl      (lvl),
    .lvl_d    (lvl_d),
    .pol      (pol_q),
    .mask     (mask_q),
    .flag_clr (flag_clr),
    .flag_q   (flag_q),
    .irq      (irq)
  );

  // Pull requests: select 1 asks for pull-down, 0 for pull-up
  always_comb begin
    pulldown_en = pull_q & pin_dir_in & pol_q;
    pullup_en   = pull_q & pin_dir_in & ~pol_q;
  end
endmodule

// File: rtl/pin_edge_irq_chk.sv
module pin_edge_irq_chk #(
  parameter int          N_PINS   = 8,
  parameter int          ADDR_W   = 8,
  parameter int unsigned OFS_FLAG = 32'h17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] pin_dir_in,
  input logic [N_PINS-1:0] pull_q,
  input logic [N_PINS-1:0] mask_q,
  input logic [N_PINS-1:0] flag_q,
  input logic [N_PINS-1:0] pullup_en,
  input logic [N_PINS-1:0] pulldown_en,
  input logic              irq
);
  // R7: request follows masked flags one cycle later
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(flag_q & mask_q)));

  // R8: never both pulls on one pin
  a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pullup_en & pulldown_en) == '0);

  // R8: a pull request needs pull-enable and input direction
  a_r8_pull_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((pullup_en | pulldown_en) & ~(pull_q & pin_dir_in)) == '0);

  // R5: a flag only falls after a write to the flag offset
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flag_q) & ~flag_q)) |->
      ($past(bus_wr) && $past(bus_addr) == ADDR_W'(OFS_FLAG)));

  // R5: a cleared bit was written with 1
  a_r5_clear_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q) & ~$past(bus_wdata)) == '0);
endmodule

bind pin_edge_irq pin_edge_irq_chk #(
  .N_PINS(N_PINS), .ADDR_W(ADDR_W), .OFS_FLAG(OFS_FLAG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .pin_dir_in  (pin_dir_in),
  .pull_q      (pull_q),
  .mask_q      (mask_q),
  .flag_q      (flag_q),
  .pullup_en   (pullup_en),
  .pulldown_en (pulldown_en),
  .irq         (irq)
);

// File: tb/pin_edge_irq_tb.sv
module pin_edge_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_PULL = 8'h14, A_POL = 8'h15, A_MASK = 8'h16, A_FLAG = 8'h17;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [7:0] pin_in, pin_dir_in, pullup_en, pulldown_en;
  logic       irq;
  int         n_checks = 0;
  int         n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_dir_in(pin_dir_in), .pullup_en(pullup_en),
    .pulldown_en(pulldown_en), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_PULL, v); check("R1 pull reg", v, 8'h00);
    rd(A_POL,  v); check("R1 select reg", v, 8'h00);
    rd(A_MASK, v); check("R1 enable reg", v, 8'h00);
    rd(A_FLAG, v); check("R1 flag reg", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(8'h18, 8'hFF);
    wr(8'h13, 8'hFF);
    rd(8'h18, v); check("R2 unmapped read", v, 8'h00);
    rd(8'h00, v); check("R2 unmapped read 0", v, 8'h00);
    rd(A_PULL, v); check("R2 no side effect pull", v, 8'h00);
    rd(A_MASK, v); check("R2 no side effect enable", v, 8'h00);
  endtask

  task automatic t_rising();
    logic [7:0] v;
    wr(A_POL, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1; settle();
    rd(A_FLAG, v); check("R3 rising sets", v, 8'h01);
    wr(A_FLAG, 8'h01);
    @(negedge clk); pin_in[0] = 1'b0; settle();
    rd(A_FLAG, v); check("R3 falling ignored", v, 8'h00);
  endtask

  task automatic t_falling();
    logic [7:0] v;
    @(negedge clk); pin_in[1] = 1'b1; settle();
    rd(A_FLAG, v); check("R4 rising ignored", v, 8'h00);
    @(negedge clk); pin_in[1] = 1'b0; settle();
    rd(A_FLAG, v); check("R4 falling sets", v, 8'h02);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(A_FLAG, 8'h00);
    rd(A_FLAG, v); check("R5 write 0 keeps", v, 8'h02);
    wr(A_FLAG, 8'hFD);
    rd(A_FLAG, v); check("R5 other bits no set", v, 8'h02);
    wr(A_FLAG, 8'h02);
    rd(A_FLAG, v); check("R5 write 1 clears", v, 8'h00);
  endtask

  task automatic t_latency_irq();
    logic [7:0] v;
    wr(A_MASK, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    rd(A_FLAG, v); check("R9 not after 2 edges", v, 8'h00);
    @(posedge clk);
    rd(A_FLAG, v); check("R9 set after 3 edges", v, 8'h01);
    check("R9 irq not yet", {7'b0, irq}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R7 irq raised", {7'b0, irq}, 8'h01);
    wr(A_MASK, 8'h00);
    @(negedge clk);
    check("R7 masked", {7'b0, irq}, 8'h00);
    wr(A_MASK, 8'h01);
    @(negedge clk);
    check("R7 unmasked", {7'b0, irq}, 8'h01);
    wr(A_FLAG, 8'h01);
    @(negedge clk);
    check("R7 irq drops after clear", {7'b0, irq}, 8'h00);
    wr(A_MASK, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    @(negedge clk); pin_in[0] = 1'b0; settle();
    @(negedge clk); pin_in[0] = 1'b1; settle();
    rd(A_FLAG, v); check("R6 prep set", v, 8'h01);
    @(negedge clk); pin_in[0] = 1'b0; settle();
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_FLAG, v); check("R6 set wins over clear", v, 8'h01);
    wr(A_FLAG, 8'h01);
    rd(A_FLAG, v); check("R6 plain clear", v, 8'h00);
  endtask

  task automatic t_pulls();
    wr(A_POL, 8'hF0);
    wr(A_PULL, 8'hCC);
    @(negedge clk); pin_dir_in = 8'hAA; #1;
    check("R8 pulldown", pulldown_en, 8'h80);
    check("R8 pullup", pullup_en, 8'h08);
    @(negedge clk); pin_dir_in = 8'hFF; #1;
    check("R8 pulldown all input", pulldown_en, 8'hC0);
    check("R8 pullup all input", pullup_en, 8'h0C);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = 8'h00; pin_dir_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unmapped();
    t_rising();
    t_falling();
    t_clear();
    t_latency_irq();
    t_collide();
    t_pulls();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule